// File: doc/BRIEF.md
# Ping-Pong Page Capture Buffer

This block absorbs a byte stream that cannot be paused and packs it into two equal banks of storage, one page per bank. Incoming bytes always land in the capture bank. When that bank holds a whole page, the bank is handed to a downstream page writer and capture moves to the other bank in the same cycle, so a steady stream keeps flowing while the earlier page is drained.

The writer sees a request, the index of the bank to drain and the page address to write it to. While the request is up, the writer reads the bank at random through a byte offset it drives, and returns a one-cycle completion pulse. The pulse frees the bank and steps the page address by one page.

The input has valid/ready handshaking, but the source is assumed unable to stall. Ready is low only when both banks hold unserviced pages. A byte offered while ready is low is discarded, and a sticky overflow flag records the loss. The page address is loaded at reset from a base input with its low offset bits cleared, and it wraps modulo 2^ADDR_W.

Top module: `pp_page_buffer`

## Requirements
- R1: While reset is asserted and after it is released, in_ready is 1, wr_req is 0, overflow is 0 and wr_addr equals base_addr with its low log2(DEPTH) bits forced to 0.
- R2: Accepted bytes fill a bank at offsets 0, 1, 2 and onwards in arrival order, and bank 0 is filled first after reset.
- R3: The clock edge that accepts the DEPTH-th byte into a bank raises wr_req. wr_req stays high until a wr_done pulse services it.
- R4: Banks are filled and served alternately: wr_buf names the oldest full bank (0 or 1), and each service moves wr_buf to the other bank.
- R5: A wr_done pulse seen while wr_req is high frees that bank and adds DEPTH to wr_addr at the next edge.
- R6: A wr_done pulse seen while wr_req is low has no effect, and wr_addr does not change.
- R7: in_ready is 0 exactly when both banks are full. A byte offered with in_valid while in_ready is 0 is discarded, never shows up in any page, and sets overflow, which stays 1 until reset.
- R8: Cycles with in_valid low store nothing and do not move the fill position.
- R9: wr_addr keeps its low log2(DEPTH) bits at 0 and wraps modulo 2^ADDR_W.
- R10: rd_data is the byte at offset rd_off of bank wr_buf, in the same cycle and with no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; also loads the base address |
| base_addr | input | ADDR_W | First page address, sampled during reset |
| in_valid | input | 1 | Input byte is present |
| in_ready | output | 1 | A capture bank has room |
| in_data | input | DATA_W | Input byte |
| wr_req | output | 1 | A full page waits for the writer |
| wr_buf | output | 1 | Index of the bank to drain |
| wr_addr | output | ADDR_W | Target page address of the pending page |
| rd_off | input | log2(DEPTH) | Writer read offset into the pending bank |
| rd_data | output | DATA_W | Byte at rd_off in the pending bank |
| wr_done | input | 1 | One-cycle pulse: pending page is written |
| overflow | output | 1 | Sticky: at least one byte was discarded |

## Verification
The block is driven with a gap-free burst, a sparse stream (one byte every third cycle), and a half-rate stream while the writer drains at the same time. The burst and the sparse stream together show that the fill position moves only on accepted bytes. The concurrent run shows that the bank swap and the page service do not interfere when they fall close together. With the writer held off, further bytes reach both banks full and test that dropped bytes never enter a page. A completion pulse sent with no page pending shows that it is ignored, and a base near the top of the address range shows the wrap.

// File: rtl/pp_buf_pkg.sv
package pp_buf_pkg;
  localparam int unsigned PP_BANKS = 2;

  typedef logic bank_t;

  function automatic bank_t other_bank(bank_t b);
    return ~b;
  endfunction
endpackage

// File: rtl/pp_fill_ctrl.sv
module pp_fill_ctrl
  import pp_buf_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic [PP_BANKS-1:0]      full_vec,
  output logic                     in_ready,
  output logic                     st_en,
  output bank_t                    st_bank,
  output logic [$clog2(DEPTH)-1:0] st_off,
  output logic                     page_closed,
  output logic                     lost
);
  localparam int OFF_W = $clog2(DEPTH);
  localparam logic [OFF_W-1:0] LAST = OFF_W'(DEPTH - 1);

  bank_t            cap_bank;
  logic [OFF_W-1:0] fill_pos;
  logic             drop;

  assign in_ready    = !full_vec[cap_bank];
  assign st_en       = in_valid && in_ready;
  assign drop        = in_valid && !in_ready;
  assign st_bank     = cap_bank;
  assign st_off      = fill_pos;
  assign page_closed = st_en && (fill_pos == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_bank <= 1'b0;
      fill_pos <= '0;
      lost     <= 1'b0;
    end else begin
      if (drop) lost <= 1'b1;
      if (st_en) begin
        if (fill_pos == LAST) begin
          fill_pos <= '0;
          cap_bank <= other_bank(cap_bank);
        end else begin
          fill_pos <= fill_pos + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pp_drain_ctrl.sv
module pp_drain_ctrl
  import pp_buf_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   base_addr,
  input  logic [PP_BANKS-1:0] full_vec,
  input  logic                done,
  output logic                req,
  output bank_t               srv_bank,
  output logic [ADDR_W-1:0]   page_addr,
  output logic                release_pg
);
  localparam int OFF_W = $clog2(DEPTH);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DEPTH);

  assign req        = full_vec[srv_bank];
  assign release_pg = req && done;

  always_ff @(posedge clk) begin
    if (rst) begin
      srv_bank  <= 1'b0;
      page_addr <= {base_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    end else if (release_pg) begin
      srv_bank  <= other_bank(srv_bank);
      page_addr <= page_addr + STEP;
    end
  end
endmodule

// File: rtl/pp_bank_store.sv
module pp_bank_store
  import pp_buf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64
) (
  input  logic                     clk,
  input  logic                     st_en,
  input  bank_t                    st_bank,
  input  logic [$clog2(DEPTH)-1:0] st_off,
  input  logic [DATA_W-1:0]        st_data,
  input  bank_t                    rd_bank,
  input  logic [$clog2(DEPTH)-1:0] rd_off,
  output logic [DATA_W-1:0]        rd_data
);
  logic [DATA_W-1:0] bank_q [PP_BANKS];

  for (genvar b = 0; b < PP_BANKS; b++) begin : g_bank
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (st_en && (st_bank == bank_t'(b))) mem[st_off] <= st_data;
    end

    assign bank_q[b] = mem[rd_off];
  end

  assign rd_data = bank_q[rd_bank];
endmodule

// File: rtl/pp_page_buffer.sv
module pp_page_buffer
  import pp_buf_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        base_addr,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [DATA_W-1:0]        in_data,
  output logic                     wr_req,
  output logic                     wr_buf,
  output logic [ADDR_W-1:0]        wr_addr,
  input  logic [$clog2(DEPTH)-1:0] rd_off,
  output logic [DATA_W-1:0]        rd_data,
  input  logic                     wr_done,
  output logic                     overflow
);
  localparam int OFF_W = $clog2(DEPTH);

  logic [PP_BANKS-1:0] full_vec;
  logic                st_en;
  bank_t               st_bank;
  logic [OFF_W-1:0]    st_off;
  logic                page_closed;
  logic                release_pg;
  bank_t               srv_bank;

  pp_fill_ctrl #(.DEPTH(DEPTH)) u_fill (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .full_vec    (full_vec),
    .in_ready    (in_ready),
    .st_en       (st_en),
    .st_bank     (st_bank),
    .st_off      (st_off),
    .page_closed (page_closed),
    .lost        (overflow)
  );

  pp_drain_ctrl #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_drain (
    .clk        (clk),
    .rst        (rst),
    .base_addr  (base_addr),
    .full_vec   (full_vec),
    .done       (wr_done),
    .req        (wr_req),
    .srv_bank   (srv_bank),
    .page_addr  (wr_addr),
    .release_pg (release_pg)
  );

  pp_bank_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .st_en   (st_en),
    .st_bank (st_bank),
    .st_off  (st_off),
    .st_data (in_data),
    .rd_bank (srv_bank),
    .rd_off  (rd_off),
    .rd_data (rd_data)
  );

  for (genvar b = 0; b < PP_BANKS; b++) begin : g_full
    always_ff @(posedge clk) begin
      if (rst)                                           full_vec[b] <= 1'b0;
      else if (page_closed && (st_bank == bank_t'(b)))   full_vec[b] <= 1'b1;
      else if (release_pg && (srv_bank == bank_t'(b)))   full_vec[b] <= 1'b0;
    end
  end

  assign wr_buf = srv_bank;
endmodule

// File: rtl/pp_page_buffer_chk.sv
module pp_page_buffer_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              wr_req,
  input logic              wr_buf,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              wr_done,
  input logic              overflow
);
  localparam int OFF_W = $clog2(DEPTH);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DEPTH);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    wr_req && !wr_done |=> wr_req); // R3

  AST_BANK_SWAP: assert property (@(posedge clk) disable iff (rst)
    wr_req && wr_done |=> wr_buf != $past(wr_buf)); // R4

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    wr_req && wr_done |=> wr_addr == $past(wr_addr) + STEP); // R5

  AST_ADDR_IDLE: assert property (@(posedge clk) disable iff (rst)
    !(wr_req && wr_done) |=> $stable(wr_addr) && $stable(wr_buf)); // R6

  AST_DROP_FLAG: assert property (@(posedge clk) disable iff (rst)
    in_valid && !in_ready |=> overflow); // R7

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow); // R7

  AST_FULL_REQ: assert property (@(posedge clk) disable iff (rst)
    !in_ready |-> wr_req); // R7

  AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (rst)
    wr_addr[OFF_W-1:0] == '0); // R9
endmodule

bind pp_page_buffer pp_page_buffer_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .wr_req   (wr_req),
  .wr_buf   (wr_buf),
  .wr_addr  (wr_addr),
  .wr_done  (wr_done),
  .overflow (overflow)
);

// File: tb/pp_page_buffer_test.sv
module pp_page_buffer_test;
  localparam int AW = 10;
  localparam int DW = 8;
  localparam int D  = 64;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] base_addr;
  logic          in_valid;
  logic          in_ready;
  logic [DW-1:0] in_data;
  logic          wr_req;
  logic          wr_buf;
  logic [AW-1:0] wr_addr;
  logic [5:0]    rd_off;
  logic [DW-1:0] rd_data;
  logic          wr_done;
  logic          overflow;

  always #5 clk = ~clk;

  pp_page_buffer #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(D)) uut (
    .clk(clk), .rst(rst), .base_addr(base_addr),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .wr_req(wr_req), .wr_buf(wr_buf), .wr_addr(wr_addr),
    .rd_off(rd_off), .rd_data(rd_data), .wr_done(wr_done),
    .overflow(overflow)
  );

  int checks = 0;
  int bad = 0;
  bit finished = 0;

  // behavioural model
  logic [DW-1:0] cur[$];
  logic [DW-1:0] pend[$];
  int            nserved = 0;
  bit            m_ovf = 0;
  int            m_base = 'h380;
  bit            drain = 0;
  int            roff = 0;
  logic [DW-1:0] seq = 8'h11;

  function automatic int npend();
    return pend.size() / D;
  endfunction

  function automatic int exp_addr();
    return (m_base + nserved * D) % (1 << AW);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(bit v, bit dn, int off);
    bit acc;
    in_valid = v;
    in_data  = seq;
    wr_done  = dn;
    rd_off   = off[5:0];
    #1;
    chk("R7 in_ready", in_ready, npend() < 2);
    chk("R3 wr_req", wr_req, npend() > 0);
    chk("R7 overflow", overflow, m_ovf);
    chk("R5 R9 wr_addr", wr_addr, exp_addr());
    if (npend() > 0) begin
      chk("R4 wr_buf", wr_buf, nserved % 2);
      chk("R2 R10 rd_data", rd_data, pend[off]);
    end
    acc = v && (npend() < 2);
    if (v && !acc) m_ovf = 1;
    if (dn && npend() > 0) begin
      for (int k = 0; k < D; k++) void'(pend.pop_front());
      nserved++;
    end
    if (acc) begin
      cur.push_back(seq);
      if (cur.size() == D) begin
        for (int k = 0; k < D; k++) pend.push_back(cur[k]);
        cur.delete();
      end
    end
    if (v) seq = seq + 8'h07;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cyc(bit v);
    bool_drain: begin end
    if (drain && npend() > 0) begin
      int o = roff;
      bit dn = (roff == D - 1);
      roff = dn ? 0 : roff + 1;
      step(v, dn, o);
    end else begin
      step(v, 1'b0, 0);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst = 1; base_addr = 10'h3A5;
    in_valid = 0; in_data = 0; wr_done = 0; rd_off = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    chk("R1 in_ready", in_ready, 1);
    chk("R1 wr_req", wr_req, 0);
    chk("R1 overflow", overflow, 0);
    chk("R1 wr_addr", wr_addr, 'h380);
    rst = 0;
    @(negedge clk);

    // R6: stray completion pulse with nothing pending
    step(1'b0, 1'b1, 0);
    chk("R6 wr_addr after stray done", wr_addr, 'h380);
    chk("R6 wr_req after stray done", wr_req, 0);

    // R2 R3: gap-free burst into bank 0
    for (int i = 0; i < D; i++) cyc(1'b1);
    #1;
    chk("R3 request after full page", wr_req, 1);
    chk("R2 first page in bank 0", wr_buf, 0);

    // R8: sparse stream into bank 1
    for (int i = 0; i < 3 * D; i++) cyc(i % 3 == 0);
    #1;
    chk("R8 R7 both banks full", in_ready, 0);

    // R7: bytes offered while full are dropped
    for (int i = 0; i < 5; i++) cyc(1'b1);
    #1;
    chk("R7 overflow sticky set", overflow, 1);

    // R5 R9: drain both pages, address wraps past the top
    drain = 1;
    for (int i = 0; i < 2 * D + 4; i++) cyc(1'b0);
    #1;
    chk("R9 wrapped page address", wr_addr, 0);
    chk("R5 no page pending", wr_req, 0);

    // concurrent half-rate stream with active writer
    for (int i = 0; i < 12 * D; i++) cyc(i % 2 == 1);
    // gap-free stream with active writer
    for (int i = 0; i < 6 * D; i++) cyc(1'b1);
    for (int i = 0; i < 3 * D; i++) cyc(1'b0);
    #1;
    chk("R4 all pages served", wr_req, 0);
    chk("R5 page count", wr_addr, exp_addr());
    summary();
  end
endmodule